// File: doc/BRIEF.md
# Disk Controller Host Register and Byte Handshake Port

This block is the host-facing register file of a disk controller that sits on an 8-bit personal-computer I/O bus with 10-bit I/O addresses. It claims a window of four byte locations. A switch value supplies the base of that window. Offset 0 is the data byte register. Offset 1 reads back a status byte and takes a control byte on writes. Offsets 2 and 3 are reserved. The host sees a request flag and two phase bits. From these it learns whether the controller wants a command byte, offers a data byte, wants a data byte, or offers the completion status byte. The host never has to count bytes.

On its inner side the block gives a command sequencer a byte interface. Each accepted command byte is forwarded with its index, and a start pulse marks the last byte. Host-written data bytes are forwarded as well, and the block reports each consumed read byte and the consumed completion byte. The sequencer opens a handshake by pulsing `seq_ready` with the phase it wants, and it can flag the end of a data block. The block also drives the host interrupt line and the DMA request line. A DMA acknowledge cycle moves a data byte without regard to the address lines. The block has five handshake states:

- **CMD_WAIT**: idle, requesting a command byte.
- **CMD_NEXT**: a one-cycle gap after each command byte but the last.
- **BUSY**: no request while the sequencer works.
- **DATA_REQ**: a data byte in either direction.
- **STAT_REQ**: the completion byte is offered.

It moves between them on these transitions:

- CMD_WAIT→CMD_NEXT on a command byte other than the last.
- CMD_NEXT→CMD_WAIT on the next cycle.
- CMD_WAIT→BUSY on the last command byte.
- BUSY→DATA_REQ on a sequencer data phase.
- BUSY→STAT_REQ on a sequencer status phase.
- DATA_REQ→BUSY when the host moves the byte.
- STAT_REQ→CMD_WAIT when the host reads the completion byte.
- Any state→CMD_WAIT on a soft reset.

Top module: `hostreg_if`

## Requirements
- R1: An access is decoded only when address bits 9..2 equal `base_sw`. Writes to any other address leave the handshake state and the forwarded outputs unchanged.
- R2: While `bus_aen` is 1 and `bus_dack` is 0, every read and write strobe is ignored.
- R3: Reads of offsets 2 and 3 return 0xFF. Writes to those offsets change nothing, even a value with bit 4 set.
- R4: After reset the status byte reads 0xE0, and `bus_irq` and `bus_dreq` are 0. The status byte has REQ in bit 7, IN/OUT in bit 6 (1 = toward controller) and COM/DTA in bit 5 (1 = command or status), with bits 4..0 at 0.
- R5: A host write to offset 0 in CMD_WAIT is forwarded on the next cycle as `cmd_valid`, `cmd_byte` and `cmd_idx` (0 for the first byte). REQ reads 0 in the cycle after the write and returns one cycle later.
- R6: The sixth command byte produces `cmd_go` alongside its `cmd_valid`. REQ then stays 0 until the sequencer opens a new phase.
- R7: `seq_ready` in BUSY opens a phase. Phase 00 puts `seq_byte` in the data register and makes the status byte 0x80. Phase 10 makes the status byte 0xC0, and the next host data write appears on `dat_wr_valid`/`dat_wr_byte`. A host data read in phase 00 pulses `dat_rd_taken`.
- R8: `bus_dreq` is 1 exactly while a data phase (00 or 10) awaits its byte. It is 0 in the command and status phases.
- R9: A strobe with `bus_dack` at 1 transfers a data byte as an offset-0 access would, whatever the address and `bus_aen` hold.
- R10: Phase 01 loads the completion byte (LUN in bits 7..5, error flag in bit 3) into the data register and makes the status byte 0xA0. Reading that byte pulses `stat_taken`, after which the status byte is 0xE0.
- R11: With interrupt enable set, a status load or a `seq_blk_done` pulse raises `bus_irq`. The line stays high until the status byte is read. A set event in the same cycle as the status read wins. With interrupt enable clear, these events leave `bus_irq` at 0.
- R12: Writing the control byte with bit 4 set returns all state to its power-up values: status 0xE0, `bus_irq` 0, interrupt enable 0 and command index 0. `soft_rst` pulses for one cycle. Control bit 6 is interrupt enable.
- R13: `seq_ready` outside BUSY is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_sw | input | 8 | Window base, compared with address bits 9..2 |
| bus_addr | input | 10 | Bus I/O address |
| bus_aen | input | 1 | Address-enable (DMA owns bus) |
| bus_ior | input | 1 | Read strobe, one-cycle pulse in `clk` domain |
| bus_iow | input | 1 | Write strobe, one-cycle pulse in `clk` domain |
| bus_dack | input | 1 | DMA acknowledge |
| bus_wdata | input | 8 | Write data from host |
| bus_rdata | output | 8 | Read data to host |
| bus_irq | output | 1 | Interrupt request |
| bus_dreq | output | 1 | DMA request |
| seq_ready | input | 1 | Sequencer opens a phase |
| seq_phase | input | 2 | {IN/OUT, COM/DTA} of that phase |
| seq_byte | input | 8 | Byte offered to host (phases 00, 01) |
| seq_blk_done | input | 1 | End of a data block |
| cmd_valid | output | 1 | Command byte forwarded |
| cmd_idx | output | 3 | Index of that byte |
| cmd_byte | output | 8 | Command byte value |
| cmd_go | output | 1 | Last command byte received |
| dat_wr_valid | output | 1 | Host data byte forwarded |
| dat_wr_byte | output | 8 | Host data byte value |
| dat_rd_taken | output | 1 | Host consumed a read data byte |
| stat_taken | output | 1 | Host consumed the completion byte |
| soft_rst | output | 1 | Soft reset pulse to sequencer |

## Verification
Two events can land on the interrupt latch in the same cycle. One is a set event: a block-done pulse or a completion-status load. The other is the host's status read, which clears the latch. The bench drives the read strobe and `seq_blk_done` in the same cycle while a data phase is open. It then expects `bus_irq` still high, and expects a later plain status read to drop it. A second overlap is a DMA-acknowledged read whose address lines point at the control or reserved offsets. It must act as a data transfer, and the bench checks it against the expected byte and the fall of `bus_dreq`.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    typedef enum logic [2:0] {
        ST_CMD_WAIT,
        ST_CMD_NEXT,
        ST_BUSY,
        ST_DATA_REQ,
        ST_STAT_REQ
    } hr_state_e;

    // {IN/OUT, COM/DTA}
    localparam logic [1:0] PH_TO_HOST   = 2'b00;
    localparam logic [1:0] PH_STATUS    = 2'b01;
    localparam logic [1:0] PH_FROM_HOST = 2'b10;
    localparam logic [1:0] PH_COMMAND   = 2'b11;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_CSR  = 2'd1;

    localparam int CTL_IE_BIT  = 6;
    localparam int CTL_RST_BIT = 4;
endpackage

// File: rtl/hostreg_decode.sv
module hostreg_decode
    import hostreg_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int SW_W  = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SW_W-1:0]   base_sw,
    input  logic              aen,
    input  logic              ior,
    input  logic              iow,
    input  logic              dack,
    output logic              rd_data,
    output logic              wr_data,
    output logic              rd_stat,
    output logic              wr_ctrl
);
    logic       hit;
    logic [1:0] ofs;

    assign ofs = addr[1:0];
    // DMA cycles bypass the decode entirely
    assign hit = !aen && !dack && (addr[ADDR_W-1:2] == base_sw);

    always_comb begin
        rd_data = ior && (dack || (hit && ofs == OFS_DATA));
        wr_data = iow && (dack || (hit && ofs == OFS_DATA));
        rd_stat = ior && hit && (ofs == OFS_CSR);
        wr_ctrl = iow && hit && (ofs == OFS_CSR);
    end
endmodule

// File: rtl/hostreg_fsm.sv
module hostreg_fsm
    import hostreg_pkg::*;
#(
    parameter int CMD_LEN = 6,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(CMD_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_now,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              seq_ready,
    input  logic [1:0]        seq_phase,
    output logic              req,
    output logic              ph_io,
    output logic              ph_cd,
    output logic              dreq,
    output logic              wr_take,
    output logic              seq_load,
    output logic              stat_load,
    output logic              cmd_valid,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_go,
    output logic              dat_wr_valid,
    output logic [DATA_W-1:0] dat_wr_byte,
    output logic              dat_rd_taken,
    output logic              stat_taken
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_LEN - 1);

    hr_state_e        state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic [1:0]       phase_q;
    logic             cmd_take, last_take, seq_take, data_done, stat_done;

    always_comb begin
        cmd_take  = (state_q == ST_CMD_WAIT) && host_wr;
        last_take = cmd_take && (cnt_q == LAST_IDX);
        seq_take  = (state_q == ST_BUSY) && seq_ready && (seq_phase != PH_COMMAND);
        data_done = (state_q == ST_DATA_REQ) && (phase_q[1] ? host_wr : host_rd);
        stat_done = (state_q == ST_STAT_REQ) && host_rd;
        wr_take   = cmd_take || ((state_q == ST_DATA_REQ) && phase_q[1] && host_wr);
        seq_load  = seq_take && !seq_phase[1];
        stat_load = seq_take && (seq_phase == PH_STATUS);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CMD_WAIT: if (cmd_take) state_d = last_take ? ST_BUSY : ST_CMD_NEXT;
            ST_CMD_NEXT: state_d = ST_CMD_WAIT;
            ST_BUSY: begin
                if (seq_take)
                    state_d = (seq_phase == PH_STATUS) ? ST_STAT_REQ : ST_DATA_REQ;
            end
            ST_DATA_REQ: if (data_done) state_d = ST_BUSY;
            ST_STAT_REQ: if (stat_done) state_d = ST_CMD_WAIT;
            default:     state_d = ST_CMD_WAIT;
        endcase
    end

    // state register, count and phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CMD_WAIT;
            cnt_q   <= '0;
            phase_q <= PH_COMMAND;
        end else if (soft_now) begin
            state_q <= ST_CMD_WAIT;
            cnt_q   <= '0;
            phase_q <= PH_COMMAND;
        end else begin
            state_q <= state_d;
            if (cmd_take)
                cnt_q <= last_take ? '0 : cnt_q + 1'b1;
            if (seq_take)
                phase_q <= seq_phase;
            else if (stat_done)
                phase_q <= PH_COMMAND;
        end
    end

    // registered strobes toward the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid    <= 1'b0;
            cmd_idx      <= '0;
            cmd_byte     <= '0;
            cmd_go       <= 1'b0;
            dat_wr_valid <= 1'b0;
            dat_wr_byte  <= '0;
            dat_rd_taken <= 1'b0;
            stat_taken   <= 1'b0;
        end else begin
            cmd_valid    <= cmd_take;
            cmd_go       <= last_take;
            dat_wr_valid <= data_done && phase_q[1];
            dat_rd_taken <= data_done && !phase_q[1];
            stat_taken   <= stat_done;
            if (cmd_take) begin
                cmd_idx  <= cnt_q;
                cmd_byte <= wdata;
            end
            if (data_done && phase_q[1])
                dat_wr_byte <= wdata;
        end
    end

    always_comb begin
        req   = (state_q == ST_CMD_WAIT) || (state_q == ST_DATA_REQ) || (state_q == ST_STAT_REQ);
        ph_io = phase_q[1];
        ph_cd = phase_q[0];
        dreq  = (state_q == ST_DATA_REQ);
    end
endmodule

// File: rtl/hostreg_irq.sv
module hostreg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic ie_bit,
    input  logic soft_now,
    input  logic stat_load,
    input  logic blk_done,
    input  logic rd_stat,
    output logic irq,
    output logic soft_rst
);
    logic ie_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q     <= 1'b0;
            irq      <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            soft_rst <= soft_now;
            if (soft_now) begin
                ie_q <= 1'b0;
                irq  <= 1'b0;
            end else begin
                if (wr_ctrl)
                    ie_q <= ie_bit;
                // a set event outranks the clearing status read
                if (ie_q && (stat_load || blk_done))
                    irq <= 1'b1;
                else if (rd_stat)
                    irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hostreg_if.sv
module hostreg_if
    import hostreg_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 8,
    parameter int CMD_LEN = 6,
    localparam int SW_W   = ADDR_W - 2,
    localparam int IDX_W  = $clog2(CMD_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SW_W-1:0]   base_sw,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_aen,
    input  logic              bus_ior,
    input  logic              bus_iow,
    input  logic              bus_dack,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_irq,
    output logic              bus_dreq,
    input  logic              seq_ready,
    input  logic [1:0]        seq_phase,
    input  logic [DATA_W-1:0] seq_byte,
    input  logic              seq_blk_done,
    output logic              cmd_valid,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [DATA_W-1:0] cmd_byte,
    output logic              cmd_go,
    output logic              dat_wr_valid,
    output logic [DATA_W-1:0] dat_wr_byte,
    output logic              dat_rd_taken,
    output logic              stat_taken,
    output logic              soft_rst
);
    logic rd_data, wr_data, rd_stat, wr_ctrl;
    logic soft_now, st_req, st_io, st_cd, wr_take, seq_load, stat_load;
    logic [DATA_W-1:0] data_q, status;

    hostreg_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr(bus_addr), .base_sw(base_sw), .aen(bus_aen),
        .ior(bus_ior), .iow(bus_iow), .dack(bus_dack),
        .rd_data(rd_data), .wr_data(wr_data), .rd_stat(rd_stat), .wr_ctrl(wr_ctrl)
    );

    assign soft_now = wr_ctrl && bus_wdata[CTL_RST_BIT];

    hostreg_fsm #(.CMD_LEN(CMD_LEN), .DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .soft_now(soft_now),
        .host_wr(wr_data), .host_rd(rd_data), .wdata(bus_wdata),
        .seq_ready(seq_ready), .seq_phase(seq_phase),
        .req(st_req), .ph_io(st_io), .ph_cd(st_cd), .dreq(bus_dreq),
        .wr_take(wr_take), .seq_load(seq_load), .stat_load(stat_load),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_byte(cmd_byte), .cmd_go(cmd_go),
        .dat_wr_valid(dat_wr_valid), .dat_wr_byte(dat_wr_byte),
        .dat_rd_taken(dat_rd_taken), .stat_taken(stat_taken)
    );

    hostreg_irq irq_i (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .ie_bit(bus_wdata[CTL_IE_BIT]),
        .soft_now(soft_now), .stat_load(stat_load), .blk_done(seq_blk_done),
        .rd_stat(rd_stat), .irq(bus_irq), .soft_rst(soft_rst)
    );

    // data in/out register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         data_q <= '0;
        else if (soft_now)  data_q <= '0;
        else if (seq_load)  data_q <= seq_byte;
        else if (wr_take)   data_q <= bus_wdata;
    end

    always_comb begin
        status = '0;
        status[DATA_W-1] = st_req;
        status[DATA_W-2] = st_io;
        status[DATA_W-3] = st_cd;
        if (rd_data)      bus_rdata = data_q;
        else if (rd_stat) bus_rdata = status;
        else              bus_rdata = '1;
    end
endmodule

// File: rtl/hostreg_chk.sv
module hostreg_chk #(
    parameter int CMD_LEN = 6
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic ph_io,
    input logic ph_cd,
    input logic dreq,
    input logic irq,
    input logic host_wr,
    input logic rd_stat,
    input logic soft_now,
    input logic stat_load,
    input logic blk_done,
    input logic cmd_valid,
    input logic cmd_go,
    input logic stat_taken,
    input logic soft_rst
);
    logic [7:0] seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                seen <= '0;
        else if (soft_now || cmd_go) seen <= '0;
        else if (cmd_valid)        seen <= seen + 8'd1;
    end

    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ph_io && ph_cd && host_wr) |=> !req);

    a_r6_go_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> (cmd_valid && seen == 8'(CMD_LEN - 1)));

    a_r8_dreq_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (req && !ph_cd));

    a_r10_idle_after_status: assert property (@(posedge clk) disable iff (!rst_n)
        stat_taken |-> (req && ph_io && ph_cd));

    a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !rd_stat && !soft_now) |=> irq);

    a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(stat_load || blk_done));

    a_r12_soft_state: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> (req && ph_io && ph_cd && !irq));
endmodule

bind hostreg_if hostreg_chk #(.CMD_LEN(CMD_LEN)) chk_i (
    .clk(clk), .rst_n(rst_n), .req(st_req), .ph_io(st_io), .ph_cd(st_cd),
    .dreq(bus_dreq), .irq(bus_irq), .host_wr(wr_data), .rd_stat(rd_stat),
    .soft_now(soft_now), .stat_load(stat_load), .blk_done(seq_blk_done),
    .cmd_valid(cmd_valid), .cmd_go(cmd_go), .stat_taken(stat_taken),
    .soft_rst(soft_rst)
);

// File: tb/hostreg_if_tb_top.sv
module hostreg_if_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [7:0] SW = 8'h5C;
    localparam logic [9:0] DA = {SW, 2'd0};
    localparam logic [9:0] CA = {SW, 2'd1};

    logic       clk = 0, rst_n = 0;
    logic [9:0] addr = '0;
    logic       aen = 0, ior = 0, iow = 0, dack = 0;
    logic [7:0] wdata = '0, rdata;
    logic       irq, dreq;
    logic       seq_ready = 0, blk = 0;
    logic [1:0] seq_phase = '0;
    logic [7:0] seq_byte = '0;
    logic       cmd_valid, cmd_go, dat_wr_valid, dat_rd_taken, stat_taken, soft_rst;
    logic [2:0] cmd_idx;
    logic [7:0] cmd_byte, dat_wr_byte;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    hostreg_if dut_i (
        .clk(clk), .rst_n(rst_n), .base_sw(SW), .bus_addr(addr), .bus_aen(aen),
        .bus_ior(ior), .bus_iow(iow), .bus_dack(dack), .bus_wdata(wdata),
        .bus_rdata(rdata), .bus_irq(irq), .bus_dreq(dreq),
        .seq_ready(seq_ready), .seq_phase(seq_phase), .seq_byte(seq_byte),
        .seq_blk_done(blk), .cmd_valid(cmd_valid), .cmd_idx(cmd_idx),
        .cmd_byte(cmd_byte), .cmd_go(cmd_go), .dat_wr_valid(dat_wr_valid),
        .dat_wr_byte(dat_wr_byte), .dat_rd_taken(dat_rd_taken),
        .stat_taken(stat_taken), .soft_rst(soft_rst)
    );

    function automatic logic [7:0] exp_status(input bit rq, input logic [1:0] ph);
        return {rq, ph, 5'b0};
    endfunction

    function automatic logic [7:0] cstat(input logic [2:0] lun, input bit err);
        return {lun, 1'b0, err, 3'b0};
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d,
                      input bit ae = 0, input bit dk = 0);
        @(negedge clk);
        addr = a; wdata = d; aen = ae; dack = dk; iow = 1;
        @(negedge clk);
        iow = 0; aen = 0; dack = 0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [7:0] d,
                      input bit ae = 0, input bit dk = 0, input bit now = 0);
        if (!now) @(negedge clk);
        addr = a; aen = ae; dack = dk; ior = 1;
        #1 d = rdata;
        @(negedge clk);
        ior = 0; aen = 0; dack = 0;
    endtask

    task automatic seq(input logic [1:0] ph, input logic [7:0] b);
        @(negedge clk);
        seq_ready = 1; seq_phase = ph; seq_byte = b;
        @(negedge clk);
        seq_ready = 0;
    endtask

    task automatic send_cmd(input bit check_gap);
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b = 8'($urandom);
            wr(DA, b);
            chk("R5 cmd_valid", cmd_valid, 1);
            chk("R5 cmd_byte", cmd_byte, b);
            chk("R5 cmd_idx", cmd_idx, i);
            chk("R6 cmd_go", cmd_go, (i == 5));
            if (check_gap && i == 0) begin
                rd(CA, v, 0, 0, 1);
                chk("R5 REQ gap", v[7], 0);
            end
        end
        rd(CA, v);
        chk("R6 busy REQ", v[7], 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, x;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // reset state
        rd(CA, v);
        chk("R4 status", v, 8'hE0);
        chk("R4 irq", irq, 0);
        chk("R4 dreq", dreq, 0);
        chk("R8 dreq cmd phase", dreq, 0);

        // reserved offsets, decode, AEN, sequencer ignored
        rd(DA + 10'd2, v);
        chk("R3 reserved read", v, 8'hFF);
        wr(DA, 8'h11);
        chk("R5 first idx", cmd_idx, 0);
        wr(DA, 8'h22);
        wr(DA + 10'd3, 8'h10);
        rd(CA, v);
        chk("R3 reserved write", v, 8'hE0);
        wr(10'h174, 8'h99);
        chk("R1 wrong base", cmd_valid, 0);
        wr(DA ^ 10'h200, 8'h98);
        chk("R1 bit9 differs", cmd_valid, 0);
        wr(DA, 8'h97, 1, 0);
        chk("R2 aen blocks", cmd_valid, 0);
        seq(2'b00, 8'h3C);
        rd(CA, v);
        chk("R13 seq ignored status", v, 8'hE0);
        rd(DA, v);
        chk("R13 seq ignored data", v, 8'h22);
        wr(DA, 8'h33);
        chk("R3 idx continues", cmd_idx, 2);
        chk("R1 match", cmd_byte, 8'h33);
        wr(DA, 8'h44); wr(DA, 8'h55); wr(DA, 8'h66);
        chk("R6 go", cmd_go, 1);

        // same-cycle interrupt set and status-read clear
        wr(CA, 8'h40);
        seq(2'b00, 8'hA5);
        chk("R8 dreq up", dreq, 1);
        @(negedge clk);
        addr = CA; ior = 1; blk = 1;
        @(negedge clk);
        ior = 0; blk = 0;
        chk("R11 set wins", irq, 1);
        rd(CA, v);
        chk("R11 read clears", irq, 0);
        // DMA read with address lines at the control offset
        rd(CA, v, 1, 1);
        chk("R9 dma data", v, 8'hA5);
        chk("R9 dma taken", dat_rd_taken, 1);
        chk("R8 dreq down", dreq, 0);

        // soft reset in a data phase with interrupt pending
        seq(2'b10, 8'h00);
        wdata = 8'h00;
        @(negedge clk); blk = 1; @(negedge clk); blk = 0;
        chk("R11 blk irq", irq, 1);
        wr(CA, 8'h50);
        chk("R12 soft pulse", soft_rst, 1);
        chk("R12 irq cleared", irq, 0);
        rd(CA, v);
        chk("R12 status", v, 8'hE0);
        send_cmd(1);
        seq(2'b01, cstat(3'd1, 1'b1));
        chk("R12 ie cleared", irq, 0);
        chk("R8 dreq status phase", dreq, 0);
        rd(DA, v);
        chk("R10 completion byte", v, cstat(3'd1, 1'b1));
        rd(CA, v);
        chk("R10 idle", v, 8'hE0);

        // random commands
        for (int n = 0; n < 24; n++) begin
            bit ie = 1'($urandom);
            bit dir = 1'($urandom);
            int k = 1 + ($urandom % 3);
            logic [2:0] lun = 3'($urandom);
            bit err = 1'($urandom);
            wr(CA, ie ? 8'h40 : 8'h00);
            send_cmd(0);
            for (int j = 0; j < k; j++) begin
                bit dm = 1'($urandom);
                x = 8'($urandom);
                seq(dir ? 2'b10 : 2'b00, dir ? 8'h00 : x);
                rd(CA, v);
                chk("R7 data phase status", v, exp_status(1, {dir, 1'b0}));
                chk("R8 dreq data", dreq, 1);
                if (dir) begin
                    wr(dm ? 10'($urandom) : DA, x, dm, dm);
                    chk("R7 dat_wr_valid", dat_wr_valid, 1);
                    chk("R7 dat_wr_byte", dat_wr_byte, x);
                end else begin
                    rd(dm ? 10'($urandom) : DA, v, dm, dm);
                    chk("R7 read byte", v, x);
                    chk("R7 dat_rd_taken", dat_rd_taken, 1);
                end
                chk("R8 dreq after", dreq, 0);
            end
            @(negedge clk); blk = 1; @(negedge clk); blk = 0;
            chk("R11 block irq", irq, ie);
            rd(CA, v);
            chk("R11 cleared", irq, 0);
            seq(2'b01, cstat(lun, err));
            chk("R11 status irq", irq, ie);
            rd(CA, v);
            chk("R10 status phase", v, 8'hA0);
            rd(DA, v);
            chk("R10 completion", v, cstat(lun, err));
            chk("R10 stat_taken", stat_taken, 1);
            rd(CA, v);
            chk("R10 back idle", v, 8'hE0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule